// File: doc/BRIEF.md
# Memory Clock Change Coordinator

This block sequences a frequency change of the clock that feeds an external DRAM memory controller. When a change is requested, it samples whether the memory controller is still held in reset. It then takes one of two ordered paths. Each path is a chain of request/acknowledge handshakes with the memory controller and with a separate PLL reprogramming sequencer.

If the controller is in reset, the coordinator keeps it in reset while the PLL is reprogrammed. It then asks for a full controller initialization. The controller counts as in reset after power-on, warm or max reset, until it has been initialized.

If the controller is running, the coordinator first blocks new accesses and waits for outstanding requests to be purged. It then parks the DRAM in self-refresh, stops the controller clock, reprograms the PLL, and turns the clock back on. Every request output is a level that is held until its acknowledge pulse arrives. A busy flag covers the whole sequence, and a one-cycle done pulse marks its end.

Top module: `mem_clk_change_coord`

## Requirements
- R1: After reset, every output (busy, done, path_act, all request outputs, mc_clk_stopped) is low.
- R2: A chg_req sampled high at a clock edge while busy is low is accepted. busy is high after that edge, and path_act is latched as the inverse of mc_in_reset at that edge (1 = active path, 0 = in-reset path).
- R3: In-reset path: pll_start is raised together with mc_rst_hold. After pll_done, init_start is raised and mc_rst_hold is low. No other request output is raised on this path.
- R4: Active path: the first step raises mc_block only. mc_block stays high through every later step up to the acknowledge of the clock re-enable. No further request is made until mc_drained.
- R5: Active path order after the drain: sref_req, then clk_off_req, then pll_start, then clk_on_req. Each step starts the cycle after the previous acknowledge.
- R6: mc_clk_stopped goes high on the clk_ack that answers clk_off_req and low on the clk_ack that answers clk_on_req. pll_start is only ever high while mc_clk_stopped or mc_rst_hold is high.
- R7: A request output stays high until its own acknowledge is sampled. Acknowledges belonging to other steps, or arriving while idle, change nothing.
- R8: While busy is high, chg_req is ignored: path_act and the step in progress do not change.
- R9: done is high for exactly one cycle, the cycle after the final acknowledge. busy is still high in that cycle and is low in the next one.
- R10: At most one of sref_req, clk_off_req, clk_on_req, pll_start, init_start is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chg_req | input | 1 | Frequency change request |
| mc_in_reset | input | 1 | Memory controller is held in reset |
| mc_drained | input | 1 | Acknowledge pulse: outstanding requests purged |
| sref_ack | input | 1 | Acknowledge pulse: DRAM in self-refresh |
| clk_ack | input | 1 | Acknowledge pulse for clock stop and clock start |
| pll_done | input | 1 | Acknowledge pulse: PLL reprogrammed |
| init_done | input | 1 | Acknowledge pulse: controller initialized |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| path_act | output | 1 | Path of the last accepted request (1 = active) |
| mc_block | output | 1 | Block new accesses and purge outstanding ones |
| sref_req | output | 1 | Request self-refresh entry |
| clk_off_req | output | 1 | Request controller clock stop |
| clk_on_req | output | 1 | Request controller clock start |
| mc_clk_stopped | output | 1 | Controller clock is stopped |
| pll_start | output | 1 | Request PLL reprogramming |
| mc_rst_hold | output | 1 | Keep the controller in reset |
| init_start | output | 1 | Request controller initialization |

## Verification
Change requests are issued with mc_in_reset randomly high or low. The bench checks which of the two step orders follows, and that the reset hold or the clock stop surrounds the PLL step. Acknowledges arrive after random delays, so a design that advances on time instead of on acknowledge is exposed. Stray acknowledges from other steps, and acknowledges while idle, separate a design that decodes its acknowledges per step from one that ORs them together. Stray change requests, including one in the done cycle, expose any re-acceptance while busy.

// File: rtl/mccc_pkg.sv
package mccc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_A_DRAIN  = 4'd1,
        ST_A_SREF   = 4'd2,
        ST_A_CLKOFF = 4'd3,
        ST_A_PLL    = 4'd4,
        ST_A_CLKON  = 4'd5,
        ST_R_PLL    = 4'd6,
        ST_R_INIT   = 4'd7,
        ST_FIN      = 4'd8
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
    } seq_regs_t;

    typedef struct packed {
        logic path_act;
    } path_regs_t;

    typedef struct packed {
        logic clk_stopped;
    } out_regs_t;

    localparam int unsigned NUM_REQ = 5;

endpackage

// File: rtl/mccc_path_sel.sv
module mccc_path_sel
    import mccc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chg_req,
    input  logic busy,
    input  logic mc_in_reset,
    output logic accept,
    output logic path_act
);

    path_regs_t path_d, path_q;

    always_comb begin
        path_d = path_q;
        accept = chg_req && !busy;
        if (accept) begin
            path_d.path_act = !mc_in_reset;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            path_q <= '0;
        end else begin
            path_q <= path_d;
        end
    end

    assign path_act = path_q.path_act;

    // R8
    ignore_busy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && chg_req) |=> $stable(path_act));

endmodule

// File: rtl/mccc_seq.sv
module mccc_seq
    import mccc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic       mc_in_reset,
    input  logic       mc_drained,
    input  logic       sref_ack,
    input  logic       clk_ack,
    input  logic       pll_done,
    input  logic       init_done,
    output seq_state_e state
);

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (accept) begin
                    seq_d.state = mc_in_reset ? ST_R_PLL : ST_A_DRAIN;
                end
            end
            ST_A_DRAIN: begin
                if (mc_drained) begin
                    seq_d.state = ST_A_SREF;
                end
            end
            ST_A_SREF: begin
                if (sref_ack) begin
                    seq_d.state = ST_A_CLKOFF;
                end
            end
            ST_A_CLKOFF: begin
                if (clk_ack) begin
                    seq_d.state = ST_A_PLL;
                end
            end
            ST_A_PLL: begin
                if (pll_done) begin
                    seq_d.state = ST_A_CLKON;
                end
            end
            ST_A_CLKON: begin
                if (clk_ack) begin
                    seq_d.state = ST_FIN;
                end
            end
            ST_R_PLL: begin
                if (pll_done) begin
                    seq_d.state = ST_R_INIT;
                end
            end
            ST_R_INIT: begin
                if (init_done) begin
                    seq_d.state = ST_FIN;
                end
            end
            ST_FIN: begin
                seq_d.state = ST_IDLE;
            end
            default: begin
                seq_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state = seq_q.state;

    // R7
    pll_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_A_PLL && !pll_done) |=> state == ST_A_PLL);

    // R7
    drain_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_A_DRAIN && !mc_drained) |=> state == ST_A_DRAIN);

    // R3
    init_after_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_R_INIT) |-> ($past(state) == ST_R_PLL || $past(state) == ST_R_INIT));

endmodule

// File: rtl/mccc_out.sv
module mccc_out
    import mccc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e state,
    input  logic       clk_ack,
    output logic       busy,
    output logic       done,
    output logic       mc_block,
    output logic       sref_req,
    output logic       clk_off_req,
    output logic       clk_on_req,
    output logic       mc_clk_stopped,
    output logic       pll_start,
    output logic       mc_rst_hold,
    output logic       init_start
);

    out_regs_t out_d, out_q;
    logic [NUM_REQ-1:0] req_vec;

    always_comb begin
        out_d = out_q;
        if (state == ST_A_CLKOFF && clk_ack) begin
            out_d.clk_stopped = 1'b1;
        end else if (state == ST_A_CLKON && clk_ack) begin
            out_d.clk_stopped = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    always_comb begin
        busy        = (state != ST_IDLE);
        done        = (state == ST_FIN);
        mc_block    = (state == ST_A_DRAIN) || (state == ST_A_SREF) ||
                      (state == ST_A_CLKOFF) || (state == ST_A_PLL) ||
                      (state == ST_A_CLKON);
        sref_req    = (state == ST_A_SREF);
        clk_off_req = (state == ST_A_CLKOFF);
        clk_on_req  = (state == ST_A_CLKON);
        pll_start   = (state == ST_A_PLL) || (state == ST_R_PLL);
        mc_rst_hold = (state == ST_R_PLL);
        init_start  = (state == ST_R_INIT);
    end

    assign mc_clk_stopped = out_q.clk_stopped;
    assign req_vec = {sref_req, clk_off_req, clk_on_req, pll_start, init_start};

    // R10
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_vec));

    // R6
    pll_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_start |-> (mc_rst_hold || mc_clk_stopped));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R3
    init_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_start |-> !mc_rst_hold);

    // R6
    clk_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mc_clk_stopped);

endmodule

// File: rtl/mem_clk_change_coord.sv
module mem_clk_change_coord
    import mccc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chg_req,
    input  logic mc_in_reset,
    input  logic mc_drained,
    input  logic sref_ack,
    input  logic clk_ack,
    input  logic pll_done,
    input  logic init_done,
    output logic busy,
    output logic done,
    output logic path_act,
    output logic mc_block,
    output logic sref_req,
    output logic clk_off_req,
    output logic clk_on_req,
    output logic mc_clk_stopped,
    output logic pll_start,
    output logic mc_rst_hold,
    output logic init_start
);

    logic       accept;
    seq_state_e state;

    mccc_path_sel u_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .chg_req     (chg_req),
        .busy        (busy),
        .mc_in_reset (mc_in_reset),
        .accept      (accept),
        .path_act    (path_act)
    );

    mccc_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .mc_in_reset (mc_in_reset),
        .mc_drained  (mc_drained),
        .sref_ack    (sref_ack),
        .clk_ack     (clk_ack),
        .pll_done    (pll_done),
        .init_done   (init_done),
        .state       (state)
    );

    mccc_out u_out (
        .clk            (clk),
        .rst_n          (rst_n),
        .state          (state),
        .clk_ack        (clk_ack),
        .busy           (busy),
        .done           (done),
        .mc_block       (mc_block),
        .sref_req       (sref_req),
        .clk_off_req    (clk_off_req),
        .clk_on_req     (clk_on_req),
        .mc_clk_stopped (mc_clk_stopped),
        .pll_start      (pll_start),
        .mc_rst_hold    (mc_rst_hold),
        .init_start     (init_start)
    );

    // R4
    block_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !mc_in_reset) |=> (mc_block && !sref_req && !pll_start));

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy && path_act == !$past(mc_in_reset)));

endmodule

// File: tb/tb_mem_clk_change_coord.sv
module tb_mem_clk_change_coord;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chg_req = 1'b0;
    logic mc_in_reset = 1'b0;
    logic mc_drained = 1'b0;
    logic sref_ack = 1'b0;
    logic clk_ack = 1'b0;
    logic pll_done = 1'b0;
    logic init_done = 1'b0;
    logic busy, done, path_act, mc_block, sref_req, clk_off_req, clk_on_req;
    logic mc_clk_stopped, pll_start, mc_rst_hold, init_start;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    mem_clk_change_coord dut (
        .clk(clk), .rst_n(rst_n), .chg_req(chg_req), .mc_in_reset(mc_in_reset),
        .mc_drained(mc_drained), .sref_ack(sref_ack), .clk_ack(clk_ack),
        .pll_done(pll_done), .init_done(init_done), .busy(busy), .done(done),
        .path_act(path_act), .mc_block(mc_block), .sref_req(sref_req),
        .clk_off_req(clk_off_req), .clk_on_req(clk_on_req),
        .mc_clk_stopped(mc_clk_stopped), .pll_start(pll_start),
        .mc_rst_hold(mc_rst_hold), .init_start(init_start)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Step codes: 1 drain, 2 self-refresh, 3 clock off, 4 PLL, 5 clock on, 6 init
    function automatic int exp_step(input bit act, input int k);
        if (act) return k + 1;
        return (k == 0) ? 4 : 6;
    endfunction

    function automatic int num_steps(input bit act);
        return act ? 5 : 2;
    endfunction

    function automatic int cur_code();
        if (sref_req) return 2;
        if (clk_off_req) return 3;
        if (pll_start) return 4;
        if (clk_on_req) return 5;
        if (init_start) return 6;
        if (mc_block) return 1;
        return 0;
    endfunction

    function automatic int ack_grp(input int code);
        if (code == 5) return 3;
        return code;
    endfunction

    task automatic drive_ack(input int code);
        case (code)
            1: mc_drained = 1'b1;
            2: sref_ack = 1'b1;
            3, 5: clk_ack = 1'b1;
            4: pll_done = 1'b1;
            6: init_done = 1'b1;
            default: ;
        endcase
    endtask

    task automatic clear_in();
        mc_drained = 1'b0; sref_ack = 1'b0; clk_ack = 1'b0;
        pll_done = 1'b0; init_done = 1'b0; chg_req = 1'b0;
    endtask

    task automatic run_txn(input bit inrst, input bit req_at_fin);
        bit act;
        int code;
        act = !inrst;
        @(negedge clk);
        mc_in_reset = inrst;
        chg_req = 1'b1;
        @(negedge clk);
        chg_req = 1'b0;
        chk(busy == 1'b1, "R2 busy", busy, 1);
        chk(path_act == act, "R2 path", path_act, act);
        for (int k = 0; k < num_steps(act); k++) begin
            code = cur_code();
            chk(code == exp_step(act, k), act ? "R5 step" : "R3 step", code, exp_step(act, k));
            chk($countones({sref_req, clk_off_req, clk_on_req, pll_start, init_start}) <= 1,
                "R10 onehot", 0, 0);
            if (act) chk(mc_block == 1'b1, "R4 block", mc_block, 1);
            if (act && code == 4) chk(mc_clk_stopped == 1'b1, "R6 stopped", mc_clk_stopped, 1);
            if (!act && code == 4) chk(mc_rst_hold == 1'b1, "R3 hold", mc_rst_hold, 1);
            if (code == 6) chk(mc_rst_hold == 1'b0, "R3 release", mc_rst_hold, 0);
            for (int d = 0; d < int'($urandom_range(0, 3)); d++) begin
                int r;
                r = $urandom_range(0, 2);
                if (r == 1) begin
                    int w;
                    w = $urandom_range(1, 6);
                    while (ack_grp(w) == ack_grp(code)) w = $urandom_range(1, 6);
                    drive_ack(w);
                end else if (r == 2) begin
                    mc_in_reset = !inrst;
                    chg_req = 1'b1;
                end
                @(negedge clk);
                clear_in();
                mc_in_reset = inrst;
                chk(cur_code() == code, "R7 hold step", cur_code(), code);
                chk(path_act == act, "R8 path kept", path_act, act);
            end
            drive_ack(code);
            @(negedge clk);
            clear_in();
        end
        chk(done == 1'b1, "R9 done", done, 1);
        chk(busy == 1'b1, "R9 busy at done", busy, 1);
        chk(cur_code() == 0, "R7 no req at done", cur_code(), 0);
        if (act) chk(mc_clk_stopped == 1'b0, "R6 restarted", mc_clk_stopped, 0);
        if (req_at_fin) begin
            mc_in_reset = !inrst;
            chg_req = 1'b1;
        end
        @(negedge clk);
        clear_in();
        mc_in_reset = inrst;
        chk(done == 1'b0, "R9 done width", done, 0);
        chk(busy == 1'b0, "R8 idle after done", busy, 0);
        chk(path_act == act, "R8 path after done", path_act, act);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({busy, done, path_act, mc_block, sref_req, clk_off_req, clk_on_req,
             mc_clk_stopped, pll_start, mc_rst_hold, init_start} == '0, "R1 reset",
            {busy, done, path_act}, 0);
        // R7 acknowledges while idle do nothing
        for (int c = 1; c <= 6; c++) begin
            drive_ack(c);
            @(negedge clk);
            clear_in();
            chk(busy == 1'b0 && cur_code() == 0 && mc_clk_stopped == 1'b0,
                "R7 idle ack", busy, 0);
        end
        // Directed corner cases: both paths, stray request in the done cycle
        run_txn(1'b0, 1'b1);
        run_txn(1'b1, 1'b1);
        run_txn(1'b0, 1'b0);
        run_txn(1'b1, 1'b0);
        for (int t = 0; t < 40; t++) begin
            run_txn(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule